// File: doc/BRIEF.md
# Multiplexed Static Memory Bus Controller

This block turns single host read and write requests of byte, halfword or word size into asynchronous accesses on an external 16-bit bus. The same 16 lines carry the address and then the data. It serves NOR flash and pseudo-static RAM placed in four banks. Each access has an address phase, a data phase and a turnaround. During the address phase an active-low address-valid strobe is asserted, and the upper word-address bits are driven on separate lines. During the data phase the output enable or the write enable is asserted together with the byte-lane enables. The length of each phase comes from static cycle-count inputs. The memory can stretch the data phase through an active-low wait input.

The host places a request for one cycle while the controller is idle. Before any bus activity, the request is checked against the device type, direction, size and mode. A request that is not allowed completes with a one-cycle error pulse. A 32-bit request is carried out as two halfword accesses and reports a single completion. The external memory is addressed in 16-bit words. The word address is the host byte address shifted right by one, with up to 26 word-address bits.

Top module: `muxbus_ctrl`

## Requirements
- R1: After reset, all chip selects, `oe_n`, `we_n`, `adv_n` and both lanes of `lane_n` are high, `ad_oe` is low, and `busy`, `done` and `err` are low.
- R2: An access starts with an address phase. In it, `adv_n` is low, `ad_out` carries word-address bits 15:0, `addr_hi` carries word-address bits 25:16, `ad_oe` is high, and the phase lasts max(`t_addr`,1) cycles. The word address is `addr` shifted right by one.
- R3: During the address and data phases exactly one chip select is low, `cs_n[bank]`. At all other times none is low.
- R4: A read data phase holds `oe_n` low and `ad_oe` low for max(`t_data`,1) cycles. `ad_in` is captured in its last cycle.
- R5: A write data phase holds `we_n` low and `ad_oe` high for max(`t_data`,1) cycles, with the write halfword on `ad_out`.
- R6: Each clock cycle in which `wait_n` is low during a data phase lengthens that phase by one cycle.
- R7: A word request (`size`=2) makes two accesses, the first to word address N and the second to N+1. Bits 15:0 of the data go to N and bits 31:16 go to N+1. There is one `done` pulse, and `rdata` is {data at N+1, data at N}.
- R8: Lane encoding: `lane_n[1]` is the upper byte and `lane_n[0]` is the lower byte, both active low, asserted only in the data phase. A byte request (`size`=0) asserts only the upper lane when `addr[0]`=1 and only the lower lane when `addr[0]`=0. Halfword (`size`=1) and word requests assert both lanes. A byte write places `wdata[7:0]` on both byte positions of `ad_out`.
- R9: A request is rejected when `size`=3, when `page_rd`=1, or when it is a byte write (`wr`=1, `size`=0) to NOR flash (`psram`=0). A rejected request gives one `err` pulse in the cycle after the request, no `done`, and no chip-select or strobe activity.
- R10: `done` pulses for one cycle in the cycle after the last turnaround ends. `rdata` is valid while `done` is high. For a byte read, `rdata` is the selected lane's byte zero-extended. For a halfword read, `rdata` is `ad_in` zero-extended.
- R11: A `req` that arrives while `busy` is high is ignored. It starts no access and produces no `err` and no extra `done`.
- R12: Every access ends with a turnaround of max(`t_turn`,1) cycles. During it all chip selects are high, all strobes are high and `ad_oe` is low. `busy` is high from the cycle after an accepted request through the last turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request strobe, taken when idle |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | 27 | Host byte address |
| bank | input | 2 | Target bank (chip select index) |
| psram | input | 1 | 1 = pseudo-static RAM, 0 = NOR flash |
| page_rd | input | 1 | Page-mode read request (always rejected) |
| wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rdata | output | 32 | Read data, valid with done |
| t_addr | input | 4 | Address phase cycles (0 is treated as 1) |
| t_data | input | 4 | Data phase cycles (0 is treated as 1) |
| t_turn | input | 4 | Turnaround cycles (0 is treated as 1) |
| cs_n | output | 4 | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |
| adv_n | output | 1 | Active-low address-valid strobe |
| lane_n | output | 2 | Active-low byte-lane enables (bit 1 upper) |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Pad driver enable for ad_out; low releases the bus |
| ad_in | input | 16 | Multiplexed data in from the pads |
| addr_hi | output | 10 | Word-address bits 25:16 |
| wait_n | input | 1 | Active-low wait from the memory |

## Verification
Most internal faults show at the ports within the access in which they occur. A wrong phase counter lengthens or shortens the address-valid, output-enable or write-enable windows. A stuck state leaves a chip select low during the turnaround, or makes the controller drive the bus while the output enable is low. A wrong half flag in a word transfer shows up as a wrong second word address, a wrong data order in `rdata`, or a second `done`. All of these are visible by the completion pulse of that request. A faulty legality decode is visible one cycle after the request, as a missing or extra `err` pulse or as a chip select that should have stayed high. Faults in the write lanes first show when the stored memory contents are read back.

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl #(
  parameter int WADDR_W = 26,
  parameter int BANKS   = 4,
  parameter int CNT_W   = 4,
  localparam int HADDR_W = WADDR_W + 1,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int HI_W    = WADDR_W - 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               wr,
  input  logic [1:0]         size,
  input  logic [HADDR_W-1:0] addr,
  input  logic [BANK_W-1:0]  bank,
  input  logic               psram,
  input  logic               page_rd,
  input  logic [31:0]        wdata,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [31:0]        rdata,
  input  logic [CNT_W-1:0]   t_addr,
  input  logic [CNT_W-1:0]   t_data,
  input  logic [CNT_W-1:0]   t_turn,
  output logic [BANKS-1:0]   cs_n,
  output logic               oe_n,
  output logic               we_n,
  output logic               adv_n,
  output logic [1:0]         lane_n,
  output logic [15:0]        ad_out,
  output logic               ad_oe,
  input  logic [15:0]        ad_in,
  output logic [HI_W-1:0]    addr_hi,
  input  logic               wait_n
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_TURN} st_t;

  localparam logic [BANKS-1:0] ONE_HOT0 = BANKS'(1);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  st_t                st;
  logic [CNT_W-1:0]   cnt;
  logic               r_wr;
  logic [1:0]         r_size;
  logic [WADDR_W-1:0] r_waddr;
  logic               r_bsel;
  logic [BANK_W-1:0]  r_bank;
  logic [31:0]        r_wdata;
  logic               second;
  logic [15:0]        lo_half;

  function automatic logic [CNT_W-1:0] last_of(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  logic illegal;
  assign illegal = (size == 2'd3) | page_rd | (!psram & wr & (size == SZ_BYTE));

  logic in_addr, in_data, rd_data, wr_data;
  assign in_addr = (st == S_ADDR);
  assign in_data = (st == S_DATA);
  assign rd_data = in_data & !r_wr;
  assign wr_data = in_data & r_wr;

  logic [15:0] wr_half;
  assign wr_half = (r_size == SZ_BYTE) ? {2{r_wdata[7:0]}} :
                   second ? r_wdata[31:16] : r_wdata[15:0];

  assign busy    = (st != S_IDLE);
  assign cs_n    = (in_addr | in_data) ? ~(ONE_HOT0 << r_bank) : '1;
  assign adv_n   = !in_addr;
  assign oe_n    = !rd_data;
  assign we_n    = !wr_data;
  assign ad_oe   = in_addr | wr_data;
  assign ad_out  = in_addr ? r_waddr[15:0] : (wr_data ? wr_half : 16'h0);
  assign addr_hi = r_waddr[WADDR_W-1:16];
  assign lane_n  = !in_data ? 2'b11 :
                   (r_size == SZ_BYTE) ? (r_bsel ? 2'b01 : 2'b10) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      r_wr    <= 1'b0;
      r_size  <= SZ_HALF;
      r_waddr <= '0;
      r_bsel  <= 1'b0;
      r_bank  <= '0;
      r_wdata <= '0;
      second  <= 1'b0;
      lo_half <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            if (illegal) begin
              err <= 1'b1;
            end else begin
              r_wr    <= wr;
              r_size  <= size;
              r_waddr <= addr[HADDR_W-1:1];
              r_bsel  <= addr[0];
              r_bank  <= bank;
              r_wdata <= wdata;
              second  <= 1'b0;
              cnt     <= last_of(t_addr);
              st      <= S_ADDR;
            end
          end
        end
        S_ADDR: begin
          if (cnt == '0) begin
            cnt <= last_of(t_data);
            st  <= S_DATA;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DATA: begin
          if (wait_n) begin
            if (cnt == '0) begin
              if (!r_wr) begin
                if (second) begin
                  rdata <= {ad_in, lo_half};
                end else begin
                  case (r_size)
                    SZ_BYTE: rdata <= {24'h0, r_bsel ? ad_in[15:8] : ad_in[7:0]};
                    SZ_WORD: lo_half <= ad_in;
                    default: rdata <= {16'h0, ad_in};
                  endcase
                end
              end
              cnt <= last_of(t_turn);
              st  <= S_TURN;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            if (r_size == SZ_WORD && !second) begin
              second  <= 1'b1;
              r_waddr <= r_waddr + 1'b1;
              cnt     <= last_of(t_addr);
              st      <= S_ADDR;
            end else begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1); // R3
  AST_ADV_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n) !adv_n |-> !(&cs_n)); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !ad_oe); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (oe_n && ad_oe)); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (in_data && !wait_n) |=> in_data); // R6
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE && req && illegal) |=> (err && !busy && &cs_n)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (busy && req) |=> !err); // R11
  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == S_TURN) |-> (&cs_n && !ad_oe && oe_n && we_n)); // R12

endmodule

// File: tb/muxbus_ctrl_tb_top.sv
module muxbus_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req = 0, wr = 0, psram = 0, page_rd = 0;
  logic [1:0]  size = 0, bank = 0;
  logic [26:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  t_addr = 2, t_data = 3, t_turn = 1;
  logic        busy, done, err, oe_n, we_n, adv_n, ad_oe;
  logic        wait_n = 1'b1;
  logic [31:0] rdata;
  logic [3:0]  cs_n;
  logic [1:0]  lane_n;
  logic [15:0] ad_out, ad_in;
  logic [9:0]  addr_hi;

  muxbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size), .addr(addr),
    .bank(bank), .psram(psram), .page_rd(page_rd), .wdata(wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .t_addr(t_addr), .t_data(t_data), .t_turn(t_turn),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .adv_n(adv_n), .lane_n(lane_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .wait_n(wait_n)
  );

  // memory model driven only by the bus pins
  logic [15:0] mem [256];
  logic [25:0] lat_addr = '0;
  function automatic logic [15:0] pat(input int i);
    return 16'(i * 257) ^ 16'h3C96;
  endfunction
  initial for (int i = 0; i < 256; i++) mem[i] = pat(i);
  always @(negedge clk) begin
    if (!adv_n) lat_addr <= {addr_hi, ad_out};
    if (!we_n) begin
      if (!lane_n[0]) mem[lat_addr[7:0]][7:0]  <= ad_out[7:0];
      if (!lane_n[1]) mem[lat_addr[7:0]][15:8] <= ad_out[15:8];
    end
  end
  assign ad_in = !oe_n ? mem[lat_addr[7:0]] : 16'h0;

  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  int n_adv, n_rd, n_wr, n_busy, n_turn, n_done, n_err, n_cs, n_cs_bad, n_bus_bad, starts;
  logic [25:0] log_addr [2];
  logic [1:0]  lane_seen;
  logic [31:0] got_rdata;

  task automatic run(input logic w, input logic [1:0] sz, input logic [26:0] a,
                     input logic [1:0] bk, input logic ps, input logic pg,
                     input logic [31:0] wd, input int waits, input bit poke);
    int wl = waits;
    logic prev_adv = 1'b1;
    n_adv = 0; n_rd = 0; n_wr = 0; n_busy = 0; n_turn = 0; n_done = 0; n_err = 0;
    n_cs = 0; n_cs_bad = 0; n_bus_bad = 0; starts = 0; lane_seen = 2'b11;
    log_addr[0] = '0; log_addr[1] = '0; got_rdata = 'x;
    @(negedge clk);
    wr = w; size = sz; addr = a; bank = bk; psram = ps; page_rd = pg; wdata = wd; req = 1;
    @(negedge clk);
    req = 0;
    for (int i = 0; i < 80; i++) begin
      if (!adv_n) n_adv++;
      if (!adv_n && prev_adv) begin
        if (starts < 2) log_addr[starts] = {addr_hi, ad_out};
        starts++;
      end
      prev_adv = adv_n;
      if (!oe_n) n_rd++;
      if (!we_n) n_wr++;
      if (busy) n_busy++;
      if (busy && &cs_n) n_turn++;
      if (!(&cs_n)) begin
        n_cs++;
        if (cs_n != ~(4'b0001 << bk)) n_cs_bad++;
      end
      if (!oe_n && ad_oe) n_bus_bad++;
      if (!we_n && !ad_oe) n_bus_bad++;
      if (!oe_n || !we_n) lane_seen = lane_n;
      if (done) begin n_done++; got_rdata = rdata; end
      if (err) n_err++;
      if ((!oe_n || !we_n) && wl > 0) begin wait_n = 0; wl--; end
      else wait_n = 1;
      if (poke && i == 2) begin wr = 1; size = 1; addr = 27'h1FE; wdata = 32'h7777; req = 1; end
      else req = 0;
      @(negedge clk);
    end
    wait_n = 1;
  endtask

  task automatic test_reset();
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 strobes", {oe_n, we_n, adv_n, lane_n}, 5'b11111);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 busy/done/err", {busy, done, err}, 3'b000);
  endtask

  task automatic test_half_read();
    run(0, 1, 27'h0A, 2, 0, 0, 0, 0, 0);
    chk("R2 word address", log_addr[0], 26'd5);
    chk("R2 adv cycles", n_adv, 2);
    chk("R3 chip select", n_cs_bad, 0);
    chk("R3 cs cycles", n_cs, 5);
    chk("R4 oe cycles", n_rd, 3);
    chk("R4 bus released", n_bus_bad, 0);
    chk("R8 half lanes", lane_seen, 2'b00);
    chk("R10 rdata half", got_rdata, {16'h0, pat(5)});
    chk("R10 one done", n_done, 1);
    chk("R12 turn cycles", n_turn, 1);
    chk("R12 busy cycles", n_busy, 6);
  endtask

  task automatic test_wait();
    run(0, 1, 27'h0A, 0, 1, 0, 0, 4, 0);
    chk("R6 stretched oe", n_rd, 7);
    chk("R6 busy cycles", n_busy, 10);
    chk("R6 rdata", got_rdata, {16'h0, pat(5)});
  endtask

  task automatic test_min_timing();
    t_addr = 0; t_data = 0; t_turn = 0;
    run(0, 1, 27'h0C, 3, 1, 0, 0, 0, 0);
    chk("R2 min adv", n_adv, 1);
    chk("R4 min oe", n_rd, 1);
    chk("R12 min busy", n_busy, 3);
    chk("R10 min rdata", got_rdata, {16'h0, pat(6)});
    t_addr = 2; t_data = 3; t_turn = 1;
  endtask

  task automatic test_high_addr();
    run(0, 1, {10'h2A5, 16'h1234, 1'b0}, 1, 1, 0, 0, 0, 0);
    chk("R2 high address", log_addr[0], 26'h2A51234);
    chk("R2 high rdata", got_rdata, {16'h0, pat(8'h34)});
  endtask

  task automatic test_byte_read();
    run(0, 0, 27'h07, 0, 0, 0, 0, 0, 0);
    chk("R8 upper lane read", lane_seen, 2'b01);
    chk("R10 byte rdata upper", got_rdata, {24'h0, pat(3)[15:8]});
    run(0, 0, 27'h06, 0, 0, 0, 0, 0, 0);
    chk("R8 lower lane read", lane_seen, 2'b10);
    chk("R10 byte rdata lower", got_rdata, {24'h0, pat(3)[7:0]});
  endtask

  task automatic test_word_read();
    run(0, 2, 27'h20, 0, 1, 0, 0, 0, 0);
    chk("R7 two accesses", starts, 2);
    chk("R7 first addr", log_addr[0], 26'd16);
    chk("R7 second addr", log_addr[1], 26'd17);
    chk("R7 combined rdata", got_rdata, {pat(17), pat(16)});
    chk("R7 single done", n_done, 1);
    chk("R12 word turns", n_turn, 2);
  endtask

  task automatic test_busy_ignored();
    run(0, 1, 27'h0A, 2, 1, 0, 0, 0, 1);
    chk("R11 one access", starts, 1);
    chk("R11 one done", n_done, 1);
    chk("R11 no err", n_err, 0);
    chk("R11 memory untouched", mem[255], pat(255));
  endtask

  task automatic test_half_write();
    run(1, 1, 27'h0C, 1, 0, 0, 32'h1234ABCD, 0, 0);
    chk("R5 we cycles", n_wr, 3);
    chk("R5 bus driven", n_bus_bad, 0);
    chk("R5 stored half", mem[6], 16'hABCD);
    chk("R3 write cs", n_cs_bad, 0);
  endtask

  task automatic test_word_write();
    run(1, 2, 27'h40, 0, 1, 0, 32'hDEADBEEF, 0, 0);
    chk("R7 low half at N", mem[32], 16'hBEEF);
    chk("R7 high half at N+1", mem[33], 16'hDEAD);
    chk("R7 write done", n_done, 1);
  endtask

  task automatic test_byte_write();
    run(1, 0, 27'h0B, 0, 1, 0, 32'hC3, 0, 0);
    chk("R8 upper lane write", lane_seen, 2'b01);
    chk("R8 upper byte stored", mem[5], {8'hC3, pat(5)[7:0]});
    run(1, 0, 27'h10, 0, 1, 0, 32'h5E, 0, 0);
    chk("R8 lower lane write", lane_seen, 2'b10);
    chk("R8 lower byte stored", mem[8], {pat(8)[15:8], 8'h5E});
  endtask

  task automatic test_reject();
    run(1, 0, 27'h04, 0, 0, 0, 32'hAA, 0, 0);
    chk("R9 nor byte write err", n_err, 1);
    chk("R9 no cs", n_cs, 0);
    chk("R9 no done", n_done, 0);
    chk("R9 not busy", n_busy, 0);
    chk("R9 memory unchanged", mem[2], pat(2));
    run(0, 3, 27'h04, 0, 1, 0, 0, 0, 0);
    chk("R9 reserved size err", n_err, 1);
    chk("R9 reserved size no cs", n_cs, 0);
    run(0, 1, 27'h04, 0, 0, 1, 0, 0, 0);
    chk("R9 page read err", n_err, 1);
    chk("R9 page read no cs", n_cs + n_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_half_read();
    test_wait();
    test_min_timing();
    test_high_addr();
    test_byte_read();
    test_word_read();
    test_busy_ignored();
    test_half_write();
    test_word_write();
    test_byte_write();
    test_reject();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule